// File: doc/BRIEF.md
# Clock-Ready Interrupt Flag Controller

This block collects the "clock is stable" indications of five clock sources: a PLL, an external high-speed crystal oscillator, an internal 16 MHz RC oscillator, an external low-speed crystal oscillator and an internal low-speed RC oscillator. Each ready line comes from another clock domain. The block passes it through a two-flop synchroniser and detects its rising edge. When the matching enable bit is set, that edge raises a sticky interrupt flag. The flags are ORed into one registered interrupt line.

Software works the block over a single-cycle register bus with byte enables. It programs the enable bits and reads the flags and an ungated edge-capture status. It removes flags by writing ones to a write-only clear register at offset 0x20. The internal 16 MHz source is a special case. Its flag is raised only if the software enable of that oscillator (input `ihs_sw_en`) is high when the edge is seen. A start caused by a peripheral clock request therefore produces no interrupt.

Register offsets:

| Offset | Access | Content |
|--------|--------|---------|
| 0x18 | read/write | interrupt enables |
| 0x1C | read-only | interrupt flags |
| 0x20 | write-only | clear register |
| 0x24 | read-only | ungated capture status |

Every register uses the same bit layout:

| Bit | Source |
|-----|--------|
| 5 | PLL |
| 4 | external high-speed oscillator |
| 3 | internal 16 MHz oscillator |
| 1 | external low-speed oscillator |
| 0 | internal low-speed oscillator |

Bit 2 and bits 31:6 are zero.

Top module: `clkrdy_irq_ctrl`

## Requirements
- R1: After reset the enables, flags, capture status and `irq` are all zero.
- R2: A rising edge on a ready input sets the flag at the matching bit position (5 PLL, 4 external high-speed, 3 internal 16 MHz, 1 external low-speed, 0 internal low-speed) when that bit's enable (offset 0x18) is set. The flag is visible at offset 0x1C three clock edges after the input rises.
- R3: No flag is set when the enable bit is clear at the edge. A ready level that is already high when the enable is set later does not set a flag, because only edges count.
- R4: The internal 16 MHz flag (bit 3) is set only if `ihs_sw_en` is high when its edge is detected. With `ihs_sw_en` low the flag stays clear even if that source is enabled.
- R5: Writing 1 to a bit of the clear register (offset 0x20, byte lane 0) clears that flag and its capture status bit. Writing 0 leaves the bit unchanged.
- R6: A write to the clear or enable register with `bus_be[0]` low changes nothing.
- R7: If a set event and a clear write hit the same bit in the same cycle, the bit ends up set.
- R8: Bit 2 and bits 31:6 of every register read as zero. A read of the clear register returns zero.
- R9: `irq` equals the OR of all flags, delayed by one clock.
- R10: The capture status (offset 0x24) records every ready rising edge, whatever the enable and `ihs_sw_en` values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | bus and flag clock |
| rst_n | input | 1 | active-low synchronous reset |
| rdy_pll | input | 1 | PLL lock indication (asynchronous) |
| rdy_xhs | input | 1 | external high-speed oscillator ready (asynchronous) |
| rdy_ihs | input | 1 | internal 16 MHz oscillator ready (asynchronous) |
| rdy_xls | input | 1 | external low-speed oscillator ready (asynchronous) |
| rdy_ils | input | 1 | internal low-speed oscillator ready (asynchronous) |
| ihs_sw_en | input | 1 | software enable of the internal 16 MHz oscillator |
| bus_sel | input | 1 | access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | byte offset |
| bus_wdata | input | DW | write data |
| bus_be | input | DW/8 | byte enables |
| bus_rdata | output | DW | read data, same cycle |
| irq | output | 1 | combined interrupt |

## Verification
The hardest case to bring about is a clear write that lands in exactly the cycle in which a synchronised edge sets the same flag.

The bench reaches it by counting edges. It raises the ready input just after a falling clock edge. It then waits two falling edges and drives a one-cycle clear write. That write is sampled at the third rising edge, the same edge at which the flag is set. An adjacent write one cycle later is used to confirm that the clear itself does work.

The internal-oscillator gating is covered by sweeping every source against both enable values and both `ihs_sw_en` values.

// File: rtl/clkrdy_irq_ctrl.sv
module clkrdy_irq_ctrl #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rdy_pll,
  input  logic          rdy_xhs,
  input  logic          rdy_ihs,
  input  logic          rdy_xls,
  input  logic          rdy_ils,
  input  logic          ihs_sw_en,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW/8-1:0] bus_be,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int NB = 6;
  localparam int IHS = 3;
  localparam logic [NB-1:0] LIVE = 6'b111011;
  localparam logic [AW-1:0] OFF_EN  = AW'(8'h18);
  localparam logic [AW-1:0] OFF_FLG = AW'(8'h1C);
  localparam logic [AW-1:0] OFF_CLR = AW'(8'h20);
  localparam logic [AW-1:0] OFF_RAW = AW'(8'h24);

  logic [NB-1:0] rdy_in, sy1, sy2, sy_prev;
  logic [NB-1:0] en_q, flg_q, raw_q;
  logic [NB-1:0] rise, set_ev, clr_ev, sw_gate;
  logic          wr0;

  assign rdy_in  = {rdy_pll, rdy_xhs, rdy_ihs, 1'b0, rdy_xls, rdy_ils};
  assign rise    = sy2 & ~sy_prev & LIVE;
  assign sw_gate = ~(NB'(!ihs_sw_en) << IHS);
  assign set_ev  = rise & en_q & sw_gate;
  assign wr0     = bus_sel & bus_wr & bus_be[0];
  assign clr_ev  = (wr0 && bus_addr == OFF_CLR) ? (bus_wdata[NB-1:0] & LIVE) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy_prev <= '0;
      en_q <= '0; flg_q <= '0; raw_q <= '0; irq <= 1'b0;
    end else begin
      sy1     <= rdy_in;
      sy2     <= sy1;
      sy_prev <= sy2;
      if (wr0 && bus_addr == OFF_EN) en_q <= bus_wdata[NB-1:0] & LIVE;
      flg_q   <= (flg_q & ~clr_ev) | set_ev;
      raw_q   <= (raw_q & ~clr_ev) | rise;
      irq     <= |flg_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFF_EN:  bus_rdata[NB-1:0] = en_q;
        OFF_FLG: bus_rdata[NB-1:0] = flg_q;
        OFF_RAW: bus_rdata[NB-1:0] = raw_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_chk
    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flg_q[i]) |-> $past(en_q[i] & rise[i])); // R3
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> flg_q[i]); // R7
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ev[i] && !rise[i]) |=> (!flg_q[i] && !raw_q[i])); // R5
    AST_RAW_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> raw_q[i]); // R10
  end

  AST_IHS_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[IHS]) |-> $past(ihs_sw_en)); // R4
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq == $past(|flg_q))); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[2] == 1'b0) && (bus_rdata[DW-1:NB] == '0)); // R8
endmodule

// File: tb/clkrdy_irq_ctrl_tb.sv
module clkrdy_irq_ctrl_tb_top;
  localparam int CLK_NS = 10;
  localparam logic [7:0] A_EN = 8'h18, A_FLG = 8'h1C, A_CLR = 8'h20, A_RAW = 8'h24;

  logic clk = 0, rst_n = 0, ihs_sw_en = 0;
  logic [5:0] rdy = '0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0] bus_be = '0;
  logic irq;
  int errs = 0, checks = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  clkrdy_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .rdy_pll(rdy[5]), .rdy_xhs(rdy[4]), .rdy_ihs(rdy[3]),
    .rdy_xls(rdy[1]), .rdy_ils(rdy[0]), .ihs_sw_en(ihs_sw_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int bits[5] = '{0, 1, 3, 4, 5};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(A_EN, v);  chk("R1 enables", v, 0);
    rd(A_FLG, v); chk("R1 flags", v, 0);
    rd(A_RAW, v); chk("R1 raw", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    foreach (bits[k]) begin
      for (int en = 0; en < 2; en++) begin
        for (int sw = 0; sw < 2; sw++) begin
          logic exp_f;
          int b = bits[k];
          exp_f = (en == 1) && (b != 3 || sw == 1);
          wr(A_EN, en ? (32'h1 << b) : 32'h0, 4'hF);
          ihs_sw_en = sw[0];
          rdy[b] = 1;
          repeat (3) @(negedge clk);
          rd(A_FLG, v);
          chk(b == 3 ? "R4 ihs gating" : (en ? "R2 flag set" : "R3 disabled"), v, exp_f ? (32'h1 << b) : 0);
          rd(A_RAW, v); chk("R10 raw capture", v, 32'h1 << b);
          @(negedge clk);
          chk("R9 irq", {31'b0, irq}, {31'b0, exp_f});
          rdy[b] = 0;
          repeat (3) @(negedge clk);
          wr(A_CLR, 32'h3F, 4'h1);
          @(negedge clk);
          rd(A_FLG, v); chk("R5 cleared", v, 0);
          chk("R9 irq low", {31'b0, irq}, 0);
        end
      end
    end
    ihs_sw_en = 0;

    wr(A_EN, 0, 4'hF);
    rdy[5] = 1;
    repeat (5) @(negedge clk);
    wr(A_EN, 32'h3B, 4'hF);
    repeat (5) @(negedge clk);
    rd(A_FLG, v); chk("R3 level no edge", v, 0);
    rdy[5] = 0;
    repeat (4) @(negedge clk);
    wr(A_CLR, 32'h3F, 4'h1);

    rdy[4] = 1; rdy[1] = 1;
    repeat (5) @(negedge clk);
    wr(A_CLR, 32'h0, 4'hF);
    rd(A_FLG, v); chk("R5 zero write", v, 32'h12);
    wr(A_CLR, 32'hFF, 4'hE);
    rd(A_FLG, v); chk("R6 lane0 off clear", v, 32'h12);
    wr(A_EN, 32'h0, 4'hE);
    rd(A_EN, v); chk("R6 lane0 off enable", v, 32'h3B);
    wr(A_CLR, 32'h10, 4'h1);
    rd(A_FLG, v); chk("R5 single clear", v, 32'h02);
    rd(A_RAW, v); chk("R5 raw cleared", v, 32'h02);
    rd(A_CLR, v); chk("R8 clear reads 0", v, 0);
    wr(A_EN, 32'hFFFF_FFFF, 4'hF);
    rd(A_EN, v); chk("R8 reserved bits", v, 32'h3B);
    rdy[4] = 0; rdy[1] = 0;
    repeat (4) @(negedge clk);
    wr(A_CLR, 32'h3F, 4'h1);

    rdy[0] = 1;
    repeat (2) @(negedge clk);
    wr(A_CLR, 32'h1, 4'h1);
    rd(A_FLG, v); chk("R7 set beats clear", v, 32'h1);
    wr(A_CLR, 32'h1, 4'h1);
    rd(A_FLG, v); chk("R7 later clear", v, 0);
    rdy[0] = 0;

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule